// File: doc/BRIEF.md
# Load/Store Execution Unit

This block executes the memory instructions of a 32-bit big-endian RISC core. It decodes the 6-bit major opcode and the register fields of an instruction word. It reads the base register and the store-data register through two index/value pairs. It forms the effective address and drives a single-cycle memory port that carries request, write strobe, address, per-byte enables and write data. Read data comes back in the following cycle. The unit aligns and extends that data and presents it as a register write-back.

Word, half-word and byte loads and stores are supported, and each load opcode sets its own size and signedness. Store instructions carry their 16-bit offset split across two fields, and the unit joins the two parts before the add. A misaligned access is refused and reported with a one-cycle flag. An opcode outside the memory group is reported with a one-cycle illegal pulse. A load that targets register 0 performs its read but never produces a write-back.

Top module: `mem_access_unit`

## Requirements
- R1: Opcodes 0x21 (word), 0x22 (word, signed), 0x23 (byte, zero-extended), 0x24 (byte, signed), 0x25 (half, zero-extended) and 0x26 (half, signed) in `insn[31:26]` are loads: `mem_req`=1, `mem_we`=0.
- R2: Opcodes 0x35 (word), 0x36 (byte) and 0x37 (half) are stores: `mem_req`=1, `mem_we`=1.
- R3: For loads, the destination index is `insn[25:21]` and the base index is `insn[20:16]`. The address is the base value plus `insn[15:0]` sign-extended to 32 bits.
- R4: For stores, the base index is `insn[20:16]` and the data index is `insn[15:11]`. The offset is `{insn[25:21], insn[10:0]}` sign-extended, added to the base value.
- R5: Byte lanes are big-endian: `mem_be[3]` covers `mem_wdata[31:24]` at address offset 0 and `mem_be[0]` covers offset 3. A word access enables all four lanes. A half enables `4'b1100` at offset 0 and `4'b0011` at offset 2. A byte enables only its own lane. Store data is a byte repeated four times, a half repeated twice, or the whole word.
- R6: Load data is taken from the lane selected by address bits [1:0] in big-endian order. It is then zero- or sign-extended to 32 bits as the opcode selects.
- R7: A load whose destination index is 0 still issues its read but never asserts `wb_en`.
- R8: A half access with address bit 0 set, or a word access with address bits [1:0] nonzero, issues no request and raises `misalign_o` for one cycle.
- R9: A valid instruction with any other opcode issues no request and raises `illegal_o` for one cycle.
- R10: The memory request appears in the same cycle as `insn_valid`. The write-back and both flags appear exactly one cycle later. With `insn_valid` low nothing is issued or reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction word is valid this cycle |
| insn | input | 32 | Instruction word |
| rf_a_idx | output | 5 | Base register index |
| rf_b_idx | output | 5 | Store data register index |
| rf_a_data | input | DATA_W | Base register value |
| rf_b_data | input | DATA_W | Store data register value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write strobe |
| mem_addr | output | ADDR_W | Effective address |
| mem_be | output | DATA_W/8 | Byte enables, bit 3 = most significant lane |
| mem_wdata | output | DATA_W | Lane-steered write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a load request |
| wb_en | output | 1 | Register write-back valid |
| wb_idx | output | 5 | Write-back register index |
| wb_data | output | DATA_W | Aligned and extended load data |
| misalign_o | output | 1 | Misaligned access pulse |
| illegal_o | output | 1 | Illegal opcode pulse |

## Verification
Address, enables, write strobe and write data depend only on the inputs of the issuing cycle. The bench therefore reads them 5 ns after driving the instruction, within the same clock period. Write-back, `misalign_o` and `illegal_o` are due one edge later. They are read 5 ns after the following falling edge, once `insn_valid` has dropped, and `mem_req` is confirmed low in that same window. A back-to-back pair checks that the first load's write-back overlaps the second load's request without mixing their lanes or indices.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
   localparam int REG_W = 5;
   localparam int IMM_W = 16;
   localparam int OPC_W = 6;

   localparam logic [OPC_W-1:0] OPC_LOAD_WU  = 6'h21;
   localparam logic [OPC_W-1:0] OPC_LOAD_WS  = 6'h22;
   localparam logic [OPC_W-1:0] OPC_LOAD_BU  = 6'h23;
   localparam logic [OPC_W-1:0] OPC_LOAD_BS  = 6'h24;
   localparam logic [OPC_W-1:0] OPC_LOAD_HU  = 6'h25;
   localparam logic [OPC_W-1:0] OPC_LOAD_HS  = 6'h26;
   localparam logic [OPC_W-1:0] OPC_STORE_W  = 6'h35;
   localparam logic [OPC_W-1:0] OPC_STORE_B  = 6'h36;
   localparam logic [OPC_W-1:0] OPC_STORE_H  = 6'h37;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } acc_size_e;

   typedef struct packed {
      logic             is_load;
      logic             is_store;
      logic             illegal;
      acc_size_e        size;
      logic             sext;
      logic [REG_W-1:0] rd;
      logic [REG_W-1:0] ra;
      logic [REG_W-1:0] rb;
      logic [IMM_W-1:0] imm;
   } dec_t;
endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
   import lsu_pkg::*;
(
   input  logic [31:0] insn,
   output dec_t        dec
);
   logic [OPC_W-1:0] opc;
   assign opc = insn[31:26];

   always_comb begin
      dec          = '0;
      dec.size     = SZ_WORD;
      dec.rd       = insn[25:21];
      dec.ra       = insn[20:16];
      dec.rb       = insn[15:11];
      unique case (opc)
         OPC_LOAD_WU: begin dec.is_load = 1'b1; dec.size = SZ_WORD;                   end
         OPC_LOAD_WS: begin dec.is_load = 1'b1; dec.size = SZ_WORD; dec.sext = 1'b1;  end
         OPC_LOAD_BU: begin dec.is_load = 1'b1; dec.size = SZ_BYTE;                   end
         OPC_LOAD_BS: begin dec.is_load = 1'b1; dec.size = SZ_BYTE; dec.sext = 1'b1;  end
         OPC_LOAD_HU: begin dec.is_load = 1'b1; dec.size = SZ_HALF;                   end
         OPC_LOAD_HS: begin dec.is_load = 1'b1; dec.size = SZ_HALF; dec.sext = 1'b1;  end
         OPC_STORE_W: begin dec.is_store = 1'b1; dec.size = SZ_WORD;                  end
         OPC_STORE_B: begin dec.is_store = 1'b1; dec.size = SZ_BYTE;                  end
         OPC_STORE_H: begin dec.is_store = 1'b1; dec.size = SZ_HALF;                  end
         default:     dec.illegal = 1'b1;
      endcase
      // stores split the offset: high five bits sit where loads keep rd
      dec.imm = dec.is_store ? {insn[25:21], insn[10:0]} : insn[15:0];
   end
endmodule

// File: rtl/lsu_agen.sv
module lsu_agen
   import lsu_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 32,
   parameter bit CHECK_ALIGN = 1'b1,
   localparam int LANES      = DATA_W / 8,
   localparam int LB         = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic [DATA_W-1:0] base,
   input  logic [IMM_W-1:0]  imm,
   input  acc_size_e         size,
   input  logic [DATA_W-1:0] store_data,
   output logic [ADDR_W-1:0] addr,
   output logic [LB-1:0]     lane_off,
   output logic [LANES-1:0]  be,
   output logic [DATA_W-1:0] wdata,
   output logic              misaligned
);
   logic [ADDR_W-1:0] imm_ext;
   assign imm_ext  = {{(ADDR_W-IMM_W){imm[IMM_W-1]}}, imm};
   assign addr     = base[ADDR_W-1:0] + imm_ext;
   assign lane_off = addr[LB-1:0];

   generate
      if (CHECK_ALIGN) begin : g_align
         always_comb begin
            unique case (size)
               SZ_HALF: misaligned = addr[0];
               SZ_WORD: misaligned = |addr[LB-1:0];
               default: misaligned = 1'b0;
            endcase
         end
      end else begin : g_noalign
         assign misaligned = 1'b0;
      end

      for (genvar i = 0; i < LANES; i++) begin : g_lane
         localparam logic [LB-1:0] IDX = LB'(i);
         logic sel;
         always_comb begin
            unique case (size)
               SZ_BYTE: sel = (lane_off == IDX);
               SZ_HALF: sel = (lane_off[LB-1:1] == IDX[LB-1:1]);
               default: sel = 1'b1;
            endcase
         end
         // lane i is address offset i, stored in the i-th most significant byte
         assign be[LANES-1-i] = sel;
         always_comb begin
            unique case (size)
               SZ_BYTE: wdata[DATA_W-1-8*i -: 8] = store_data[7:0];
               SZ_HALF: wdata[DATA_W-1-8*i -: 8] = (i % 2 == 0) ? store_data[15:8]
                                                                 : store_data[7:0];
               default: wdata[DATA_W-1-8*i -: 8] = store_data[DATA_W-1-8*i -: 8];
            endcase
         end
      end
   endgenerate

   AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (active && size == SZ_BYTE) |-> ($countones(be) == 1)); // R5
   AST_WORD_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (active && size == SZ_WORD) |-> (&be)); // R5
endmodule

// File: rtl/lsu_extract.sv
module lsu_extract
   import lsu_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int LB    = $clog2(LANES)
) (
   input  logic [DATA_W-1:0] rdata,
   input  logic [LB-1:0]     lane_off,
   input  acc_size_e         size,
   input  logic              sext,
   output logic [DATA_W-1:0] data
);
   logic [DATA_W-1:0] shifted;
   logic [7:0]        byte_v;
   logic [15:0]       half_v;

   // bring the addressed lane to the top, big-endian
   assign shifted = rdata << {lane_off, 3'b000};
   assign byte_v  = shifted[DATA_W-1 -: 8];
   assign half_v  = shifted[DATA_W-1 -: 16];

   always_comb begin
      unique case (size)
         SZ_BYTE: data = {{(DATA_W-8){sext & byte_v[7]}}, byte_v};
         SZ_HALF: data = {{(DATA_W-16){sext & half_v[15]}}, half_v};
         default: data = rdata;
      endcase
   end
endmodule

// File: rtl/mem_access_unit.sv
module mem_access_unit
   import lsu_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 32,
   parameter bit CHECK_ALIGN = 1'b1,
   localparam int LANES      = DATA_W / 8,
   localparam int LB         = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              insn_valid,
   input  logic [31:0]       insn,
   output logic [REG_W-1:0]  rf_a_idx,
   output logic [REG_W-1:0]  rf_b_idx,
   input  logic [DATA_W-1:0] rf_a_data,
   input  logic [DATA_W-1:0] rf_b_data,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [LANES-1:0]  mem_be,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              wb_en,
   output logic [REG_W-1:0]  wb_idx,
   output logic [DATA_W-1:0] wb_data,
   output logic              misalign_o,
   output logic              illegal_o
);
   generate
      if (DATA_W != 32) begin : g_bad_data_w
         $error("mem_access_unit: DATA_W must be 32");
      end
      if (ADDR_W < IMM_W || ADDR_W > DATA_W) begin : g_bad_addr_w
         $error("mem_access_unit: ADDR_W must lie between IMM_W and DATA_W");
      end
   endgenerate

   dec_t            dec;
   logic            is_mem;
   logic            misaligned;
   logic [LB-1:0]   lane_off;

   logic            ld_pend;
   logic [REG_W-1:0] ld_idx;
   acc_size_e       ld_size;
   logic            ld_sext;
   logic [LB-1:0]   ld_off;
   logic            mis_q;
   logic            ill_q;

   lsu_decode u_dec (
      .insn (insn),
      .dec  (dec)
   );

   assign rf_a_idx = dec.ra;
   assign rf_b_idx = dec.rb;
   assign is_mem   = insn_valid && (dec.is_load || dec.is_store);

   lsu_agen #(
      .DATA_W      (DATA_W),
      .ADDR_W      (ADDR_W),
      .CHECK_ALIGN (CHECK_ALIGN)
   ) u_agen (
      .clk        (clk),
      .rst_n      (rst_n),
      .active     (mem_req),
      .base       (rf_a_data),
      .imm        (dec.imm),
      .size       (dec.size),
      .store_data (rf_b_data),
      .addr       (mem_addr),
      .lane_off   (lane_off),
      .be         (mem_be),
      .wdata      (mem_wdata),
      .misaligned (misaligned)
   );

   assign mem_req = is_mem && !misaligned;
   assign mem_we  = mem_req && dec.is_store;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_pend <= 1'b0;
         ld_idx  <= '0;
         ld_size <= SZ_WORD;
         ld_sext <= 1'b0;
         ld_off  <= '0;
         mis_q   <= 1'b0;
         ill_q   <= 1'b0;
      end else begin
         ld_pend <= mem_req && dec.is_load && (dec.rd != '0);
         mis_q   <= is_mem && misaligned;
         ill_q   <= insn_valid && dec.illegal;
         if (mem_req && dec.is_load) begin
            ld_idx  <= dec.rd;
            ld_size <= dec.size;
            ld_sext <= dec.sext;
            ld_off  <= lane_off;
         end
      end
   end

   lsu_extract #(
      .DATA_W (DATA_W)
   ) u_ext (
      .rdata    (mem_rdata),
      .lane_off (ld_off),
      .size     (ld_size),
      .sext     (ld_sext),
      .data     (wb_data)
   );

   assign wb_en      = ld_pend;
   assign wb_idx     = ld_idx;
   assign misalign_o = mis_q;
   assign illegal_o  = ill_q;

   AST_WB_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> $past(mem_req && !mem_we)); // R10
   AST_WB_NOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (wb_idx != '0)); // R7
   AST_MISALIGN_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      misalign_o |-> $past(!mem_req)); // R8
   AST_ILLEGAL_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> $past(!mem_req)); // R9
   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(misalign_o && illegal_o)); // R9
endmodule

// File: tb/tb_mem_access_unit.sv
`timescale 1ns/1ps
module tb_mem_access_unit;
   localparam logic [31:0] RD = 32'h8A7B_C6F1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        insn_valid = 1'b0;
   logic [31:0] insn = '0;
   logic [4:0]  rf_a_idx, rf_b_idx;
   logic [31:0] rf_a_data = '0, rf_b_data = '0;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = RD;
   logic        wb_en;
   logic [4:0]  wb_idx;
   logic [31:0] wb_data;
   logic        misalign_o, illegal_o;

   int n_run = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   mem_access_unit dut (
      .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
      .rf_a_idx(rf_a_idx), .rf_b_idx(rf_b_idx),
      .rf_a_data(rf_a_data), .rf_b_data(rf_b_data),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
      .misalign_o(misalign_o), .illegal_o(illegal_o)
   );

   function automatic logic [31:0] enc_ld(logic [5:0] op, logic [4:0] rd,
                                          logic [4:0] ra, logic [15:0] imm);
      return {op, rd, ra, imm};
   endfunction

   function automatic logic [31:0] enc_st(logic [5:0] op, logic [4:0] ra,
                                          logic [4:0] rb, logic [15:0] imm);
      return {op, imm[15:11], ra, rb, imm[10:0]};
   endfunction

   typedef struct packed {
      logic [31:0] insn;
      logic [31:0] base;
      logic [31:0] sdat;
      logic        req;
      logic        we;
      logic [31:0] addr;
      logic [3:0]  be;
      logic [31:0] wdata;
      logic        wbe;
      logic [4:0]  wbi;
      logic [31:0] wb;
      logic        mis;
      logic        ill;
   } vec_t;

   localparam int NV = 24;
   localparam vec_t VECS [NV] = '{
      '{enc_ld(6'h21, 5'd3, 5'd1, 16'h0010), 32'h1000, 32'h0, 1'b1, 1'b0, 32'h1010, 4'hF, 32'h0, 1'b1, 5'd3, 32'h8A7BC6F1, 1'b0, 1'b0},
      '{enc_ld(6'h22, 5'd4, 5'd1, 16'hFFFC), 32'h2008, 32'h0, 1'b1, 1'b0, 32'h2004, 4'hF, 32'h0, 1'b1, 5'd4, 32'h8A7BC6F1, 1'b0, 1'b0},
      '{enc_ld(6'h23, 5'd5, 5'd2, 16'h0001), 32'h0100, 32'h0, 1'b1, 1'b0, 32'h0101, 4'h4, 32'h0, 1'b1, 5'd5, 32'h0000007B, 1'b0, 1'b0},
      '{enc_ld(6'h24, 5'd6, 5'd2, 16'h0000), 32'h0100, 32'h0, 1'b1, 1'b0, 32'h0100, 4'h8, 32'h0, 1'b1, 5'd6, 32'hFFFFFF8A, 1'b0, 1'b0},
      '{enc_ld(6'h24, 5'd7, 5'd2, 16'h0003), 32'h0100, 32'h0, 1'b1, 1'b0, 32'h0103, 4'h1, 32'h0, 1'b1, 5'd7, 32'hFFFFFFF1, 1'b0, 1'b0},
      '{enc_ld(6'h23, 5'd8, 5'd2, 16'h0002), 32'h0100, 32'h0, 1'b1, 1'b0, 32'h0102, 4'h2, 32'h0, 1'b1, 5'd8, 32'h000000C6, 1'b0, 1'b0},
      '{enc_ld(6'h25, 5'd9, 5'd3, 16'h0002), 32'h0200, 32'h0, 1'b1, 1'b0, 32'h0202, 4'h3, 32'h0, 1'b1, 5'd9, 32'h0000C6F1, 1'b0, 1'b0},
      '{enc_ld(6'h26, 5'd10, 5'd3, 16'h0000), 32'h0200, 32'h0, 1'b1, 1'b0, 32'h0200, 4'hC, 32'h0, 1'b1, 5'd10, 32'hFFFF8A7B, 1'b0, 1'b0},
      '{enc_ld(6'h26, 5'd11, 5'd3, 16'hFFFE), 32'h0204, 32'h0, 1'b1, 1'b0, 32'h0202, 4'h3, 32'h0, 1'b1, 5'd11, 32'hFFFFC6F1, 1'b0, 1'b0},
      '{enc_ld(6'h25, 5'd12, 5'd3, 16'h0000), 32'h0200, 32'h0, 1'b1, 1'b0, 32'h0200, 4'hC, 32'h0, 1'b1, 5'd12, 32'h00008A7B, 1'b0, 1'b0},
      '{enc_ld(6'h24, 5'd13, 5'd2, 16'h0001), 32'h0100, 32'h0, 1'b1, 1'b0, 32'h0101, 4'h4, 32'h0, 1'b1, 5'd13, 32'h0000007B, 1'b0, 1'b0},
      '{enc_st(6'h35, 5'd2, 5'd7, 16'h0008), 32'h3000, 32'h11223344, 1'b1, 1'b1, 32'h3008, 4'hF, 32'h11223344, 1'b0, 5'd0, 32'h0, 1'b0, 1'b0},
      '{enc_st(6'h36, 5'd2, 5'd7, 16'h0003), 32'h3000, 32'hAABBCCDD, 1'b1, 1'b1, 32'h3003, 4'h1, 32'hDDDDDDDD, 1'b0, 5'd0, 32'h0, 1'b0, 1'b0},
      '{enc_st(6'h36, 5'd2, 5'd7, 16'hF805), 32'h4000, 32'hAABBCCDD, 1'b1, 1'b1, 32'h3805, 4'h4, 32'hDDDDDDDD, 1'b0, 5'd0, 32'h0, 1'b0, 1'b0},
      '{enc_st(6'h37, 5'd2, 5'd7, 16'h0802), 32'h5000, 32'hAABBCCDD, 1'b1, 1'b1, 32'h5802, 4'h3, 32'hCCDDCCDD, 1'b0, 5'd0, 32'h0, 1'b0, 1'b0},
      '{enc_st(6'h37, 5'd2, 5'd7, 16'h0000), 32'h5000, 32'hAABBCCDD, 1'b1, 1'b1, 32'h5000, 4'hC, 32'hCCDDCCDD, 1'b0, 5'd0, 32'h0, 1'b0, 1'b0},
      '{enc_ld(6'h25, 5'd9, 5'd3, 16'h0001), 32'h0200, 32'h0, 1'b0, 1'b0, 32'h0, 4'h0, 32'h0, 1'b0, 5'd0, 32'h0, 1'b1, 1'b0},
      '{enc_ld(6'h21, 5'd9, 5'd3, 16'h0002), 32'h0200, 32'h0, 1'b0, 1'b0, 32'h0, 4'h0, 32'h0, 1'b0, 5'd0, 32'h0, 1'b1, 1'b0},
      '{enc_st(6'h35, 5'd2, 5'd7, 16'h0001), 32'h3000, 32'h0, 1'b0, 1'b0, 32'h0, 4'h0, 32'h0, 1'b0, 5'd0, 32'h0, 1'b1, 1'b0},
      '{enc_st(6'h37, 5'd2, 5'd7, 16'h0003), 32'h3000, 32'h0, 1'b0, 1'b0, 32'h0, 4'h0, 32'h0, 1'b0, 5'd0, 32'h0, 1'b1, 1'b0},
      '{{6'h20, 26'h0}, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 4'h0, 32'h0, 1'b0, 5'd0, 32'h0, 1'b0, 1'b1},
      '{{6'h34, 26'h0}, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 4'h0, 32'h0, 1'b0, 5'd0, 32'h0, 1'b0, 1'b1},
      '{enc_ld(6'h21, 5'd0, 5'd1, 16'h0000), 32'h1000, 32'h0, 1'b1, 1'b0, 32'h1000, 4'hF, 32'h0, 1'b0, 5'd0, 32'h0, 1'b0, 1'b0},
      '{enc_ld(6'h21, 5'd31, 5'd1, 16'h0004), 32'h0FFC, 32'h0, 1'b1, 1'b0, 32'h1000, 4'hF, 32'h0, 1'b1, 5'd31, 32'h8A7BC6F1, 1'b0, 1'b0}
   };

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic issue(logic [31:0] w, logic [31:0] a, logic [31:0] b);
      @(negedge clk);
      insn_valid = 1'b1;
      insn       = w;
      rf_a_data  = a;
      rf_b_data  = b;
      #5;
   endtask

   initial begin
      #(20 * 100000);
      n_fail++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      // reset state
      repeat (2) @(negedge clk);
      #5;
      chk("R10", "reset mem_req", 32'(mem_req), 32'd0);
      chk("R10", "reset wb_en", 32'(wb_en), 32'd0);
      chk("R8", "reset misalign", 32'(misalign_o), 32'd0);
      chk("R9", "reset illegal", 32'(illegal_o), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // vector table
      for (int k = 0; k < NV; k++) begin
         automatic vec_t v = VECS[k];
         automatic bit   st = (v.insn[31:26] >= 6'h30);
         issue(v.insn, v.base, v.sdat);
         chk(st ? "R2" : "R1", "mem_req", 32'(mem_req), 32'(v.req));
         if (v.req) begin
            chk(st ? "R2" : "R1", "mem_we", 32'(mem_we), 32'(v.we));
            chk(st ? "R4" : "R3", "mem_addr", mem_addr, v.addr);
            chk("R5", "mem_be", 32'(mem_be), 32'(v.be));
            if (v.we) chk("R5", "mem_wdata", mem_wdata, v.wdata);
         end
         @(negedge clk);
         insn_valid = 1'b0;
         #5;
         chk("R10", "req after valid drop", 32'(mem_req), 32'd0);
         chk((v.insn[25:21] == 5'd0 && !st) ? "R7" : "R10", "wb_en", 32'(wb_en), 32'(v.wbe));
         if (v.wbe) begin
            chk("R3", "wb_idx", 32'(wb_idx), 32'(v.wbi));
            chk("R6", "wb_data", wb_data, v.wb);
         end
         chk("R8", "misalign_o", 32'(misalign_o), 32'(v.mis));
         chk("R9", "illegal_o", 32'(illegal_o), 32'(v.ill));
      end

      // register index fields
      issue(enc_st(6'h35, 5'd17, 5'd22, 16'h0), 32'h0, 32'h0);
      chk("R4", "store base idx", 32'(rf_a_idx), 32'd17);
      chk("R4", "store data idx", 32'(rf_b_idx), 32'd22);
      insn = enc_ld(6'h21, 5'd9, 5'd14, 16'h0);
      #1;
      chk("R3", "load base idx", 32'(rf_a_idx), 32'd14);

      // no valid: nothing issued, nothing reported
      @(negedge clk);
      insn_valid = 1'b0;
      insn       = enc_ld(6'h21, 5'd9, 5'd14, 16'h0);
      #5;
      chk("R10", "idle mem_req", 32'(mem_req), 32'd0);
      @(negedge clk);
      #5;
      chk("R10", "idle wb_en", 32'(wb_en), 32'd0);
      insn = {6'h3F, 26'h0};
      @(negedge clk);
      #5;
      chk("R9", "idle illegal", 32'(illegal_o), 32'd0);

      // back-to-back loads
      issue(enc_ld(6'h23, 5'd5, 5'd2, 16'h0003), 32'h0100, 32'h0);
      chk("R1", "b2b first req", 32'(mem_req), 32'd1);
      issue(enc_ld(6'h26, 5'd6, 5'd2, 16'h0000), 32'h0100, 32'h0);
      chk("R10", "b2b second req", 32'(mem_req), 32'd1);
      chk("R10", "b2b first wb_en", 32'(wb_en), 32'd1);
      chk("R10", "b2b first wb_idx", 32'(wb_idx), 32'd5);
      chk("R6", "b2b first wb_data", wb_data, 32'h000000F1);
      @(negedge clk);
      insn_valid = 1'b0;
      #5;
      chk("R10", "b2b second wb_idx", 32'(wb_idx), 32'd6);
      chk("R6", "b2b second wb_data", wb_data, 32'hFFFF8A7B);
      @(negedge clk);
      #5;
      chk("R10", "b2b drained wb_en", 32'(wb_en), 32'd0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule